// File: doc/BRIEF.md
# Offset-Adjusting Eight-Bit ALU with Result Freeze

This block is the arithmetic and logic unit behind two accumulator registers and a function register. Software loads the operands into the two accumulators and then writes an opcode byte into the function register. The low nibble of that byte picks one of sixteen operations. The top three bits give a small signed constant, and the block adds it to whatever the operation produced. The result and a zero flag are always visible on the outputs. A branch unit uses the zero flag to decide conditional jumps.

An accumulator is often reloaded after a computation only to serve as an address. The block therefore freezes its result whenever an accumulator is written. In the live state (`ST_LIVE`) the output follows the operands and the opcode. An accumulator write without a simultaneous function write takes the freeze transition into `ST_FROZEN`. The value shown just before that write is then held. Any later function write takes the thaw transition back to `ST_LIVE`, and the result is recomputed from the current operands. When both an accumulator and the function register are written in the same cycle, the function write wins: the block stays or becomes live, and the new operand is used.

Top module: `alu_offset_hold`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both accumulators are zero and the function is pass-A with offset 0. The result is therefore 0x00 and the zero flag is 1.
- R2: Function codes 0 to 7 (opcode bits 3:0) give the following results:
    - 0 passes A and 1 passes B.
    - 2 and 3 give the bitwise inverse of A and of B.
    - 4 and 5 shift A and B left by one.
    - 6 and 7 shift A and B right by one.
    - Every shift fills the vacated bit with 0.
- R3: Function codes 8, 9 and 10 give A AND B, A OR B and A XOR B.
- R4: Function code 11 gives the low eight bits of A+B. Function code 12 gives 0x01 when A+B exceeds 255 and 0x00 otherwise.
- R5: Function codes 13, 14 and 15 give 0xFF when A<B, A==B and A>B respectively, and 0x00 otherwise. The comparison is unsigned.
- R6: Opcode bits 7:5 are a two's-complement value from -4 to +3. It is added to the operation result modulo 256.
- R7: Opcode bit 4 has no effect on the result.
- R8: A cycle that writes A or B but not the function register freezes the output. In the following cycle the result equals the value shown before the write.
- R9: While frozen, further writes to A or B leave the result unchanged.
- R10: A function write takes effect one cycle later and releases any freeze. The result then reflects the new opcode with the accumulator values as updated in that same cycle.
- R11: The zero flag is 1 exactly when the final result, offset included, is 0x00. This holds in both the live and the frozen state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_we | input | 1 | Write strobe for accumulator A |
| a_wdata | input | 8 | Data for accumulator A |
| b_we | input | 1 | Write strobe for accumulator B |
| b_wdata | input | 8 | Data for accumulator B |
| f_we | input | 1 | Write strobe for the function register |
| f_wdata | input | 8 | Opcode byte: bits 7:5 offset, bit 4 unused, bits 3:0 operation |
| result | output | 8 | Final result, live or frozen |
| zero | output | 1 | High when result is 0x00 |

## Verification
A stuck or wrongly entered freeze state shows at the ports on the first cycle after the next operand write. A missed freeze shows the new operand's effect at once. A missed thaw leaves a stale value after the next function write. A corrupt snapshot shows the moment the block freezes. A wrong operand or opcode register stays hidden while frozen and appears one cycle after the next function write. The bench therefore compares the outputs against an independent model on every cycle, across long runs of random strobe mixes.

// File: rtl/alu_offset_hold_pkg.sv
package alu_offset_hold_pkg;

    typedef enum logic [3:0] {
        FN_PASS_A  = 4'd0,
        FN_PASS_B  = 4'd1,
        FN_INV_A   = 4'd2,
        FN_INV_B   = 4'd3,
        FN_SHL_A   = 4'd4,
        FN_SHL_B   = 4'd5,
        FN_SHR_A   = 4'd6,
        FN_SHR_B   = 4'd7,
        FN_AND     = 4'd8,
        FN_OR      = 4'd9,
        FN_XOR     = 4'd10,
        FN_SUM     = 4'd11,
        FN_CARRY   = 4'd12,
        FN_LESS    = 4'd13,
        FN_EQUAL   = 4'd14,
        FN_GREATER = 4'd15
    } alu_fn_e;

    typedef enum logic {
        ST_LIVE   = 1'b0,
        ST_FROZEN = 1'b1
    } hold_state_e;

endpackage

// File: rtl/alu_operand_regs.sv
module alu_operand_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_we,
    input  logic [WIDTH-1:0] a_wdata,
    input  logic             b_we,
    input  logic [WIDTH-1:0] b_wdata,
    input  logic             f_we,
    input  logic [WIDTH-1:0] f_wdata,
    output logic [WIDTH-1:0] opnd_a,
    output logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] opcode
);
    localparam int NUM_ACC = 2;

    logic [NUM_ACC-1:0]            acc_we;
    logic [NUM_ACC-1:0][WIDTH-1:0] acc_wdata;
    logic [NUM_ACC-1:0][WIDTH-1:0] acc_q;

    assign acc_we    = {b_we, a_we};
    assign acc_wdata = {b_wdata, a_wdata};

    for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[i] <= '0;
            end else if (acc_we[i]) begin
                acc_q[i] <= acc_wdata[i];
            end
        end
    end

    // Reset function: pass A, offset zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode <= '0;
        end else if (f_we) begin
            opcode <= f_wdata;
        end
    end

    assign opnd_a = acc_q[0];
    assign opnd_b = acc_q[1];

endmodule

// File: rtl/alu_compute.sv
module alu_compute
    import alu_offset_hold_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int OFS_W = 3
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [WIDTH-1:0] opcode,
    output logic [WIDTH-1:0] live_result,
    output logic             live_zero
);
    localparam int SEL_W = 4;
    localparam int PAD_W = WIDTH - OFS_W;

    alu_fn_e          fn;
    logic [WIDTH:0]   wide_sum;
    logic [WIDTH-1:0] base;
    logic [WIDTH-1:0] ofs_ext;
    logic [PAD_W-SEL_W-1:0] spare_bits_unused;

    assign fn                = alu_fn_e'(opcode[SEL_W-1:0]);
    assign spare_bits_unused = opcode[PAD_W-1:SEL_W];
    assign wide_sum          = {1'b0, opnd_a} + {1'b0, opnd_b};
    assign ofs_ext           = {{PAD_W{opcode[WIDTH-1]}}, opcode[WIDTH-1 -: OFS_W]};

    always_comb begin
        unique case (fn)
            FN_PASS_A:  base = opnd_a;
            FN_PASS_B:  base = opnd_b;
            FN_INV_A:   base = ~opnd_a;
            FN_INV_B:   base = ~opnd_b;
            FN_SHL_A:   base = opnd_a << 1;
            FN_SHL_B:   base = opnd_b << 1;
            FN_SHR_A:   base = opnd_a >> 1;
            FN_SHR_B:   base = opnd_b >> 1;
            FN_AND:     base = opnd_a & opnd_b;
            FN_OR:      base = opnd_a | opnd_b;
            FN_XOR:     base = opnd_a ^ opnd_b;
            FN_SUM:     base = wide_sum[WIDTH-1:0];
            FN_CARRY:   base = {{(WIDTH-1){1'b0}}, wide_sum[WIDTH]};
            FN_LESS:    base = (opnd_a <  opnd_b) ? '1 : '0;
            FN_EQUAL:   base = (opnd_a == opnd_b) ? '1 : '0;
            FN_GREATER: base = (opnd_a >  opnd_b) ? '1 : '0;
            default:    base = '0;
        endcase
    end

    assign live_result = base + ofs_ext;
    assign live_zero   = (live_result == '0);

endmodule

// File: rtl/alu_hold_fsm.sv
module alu_hold_fsm
    import alu_offset_hold_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             opnd_write,
    input  logic             fn_write,
    input  logic [WIDTH-1:0] live_result,
    input  logic             live_zero,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             frozen
);
    hold_state_e      state_q;
    hold_state_e      state_d;
    logic [WIDTH-1:0] snap_result;
    logic             snap_zero;
    logic             take_freeze;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LIVE:   if (opnd_write && !fn_write) state_d = ST_FROZEN;
            ST_FROZEN: if (fn_write)                state_d = ST_LIVE;
            default:   state_d = ST_LIVE;
        endcase
    end

    assign take_freeze = (state_q == ST_LIVE) && (state_d == ST_FROZEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_LIVE;
            snap_result <= '0;
            snap_zero   <= 1'b1;
        end else begin
            state_q <= state_d;
            if (take_freeze) begin
                snap_result <= live_result;
                snap_zero   <= live_zero;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_FROZEN: begin
                result = snap_result;
                zero   = snap_zero;
                frozen = 1'b1;
            end
            default: begin
                result = live_result;
                zero   = live_zero;
                frozen = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_offset_hold.sv
module alu_offset_hold #(
    parameter int WIDTH = 8,
    parameter int OFS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_we,
    input  logic [WIDTH-1:0] a_wdata,
    input  logic             b_we,
    input  logic [WIDTH-1:0] b_wdata,
    input  logic             f_we,
    input  logic [WIDTH-1:0] f_wdata,
    output logic [WIDTH-1:0] result,
    output logic             zero
);
    logic [WIDTH-1:0] opnd_a;
    logic [WIDTH-1:0] opnd_b;
    logic [WIDTH-1:0] opcode;
    logic [WIDTH-1:0] live_result;
    logic             live_zero;
    logic             frozen;

    alu_operand_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (a_we),
        .a_wdata (a_wdata),
        .b_we    (b_we),
        .b_wdata (b_wdata),
        .f_we    (f_we),
        .f_wdata (f_wdata),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .opcode  (opcode)
    );

    alu_compute #(.WIDTH(WIDTH), .OFS_W(OFS_W)) u_core (
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b),
        .opcode      (opcode),
        .live_result (live_result),
        .live_zero   (live_zero)
    );

    alu_hold_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .opnd_write  (a_we | b_we),
        .fn_write    (f_we),
        .live_result (live_result),
        .live_zero   (live_zero),
        .result      (result),
        .zero        (zero),
        .frozen      (frozen)
    );

endmodule

// File: rtl/alu_offset_hold_checker.sv
module alu_offset_hold_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_we,
    input logic             b_we,
    input logic             f_we,
    input logic [WIDTH-1:0] result,
    input logic             zero,
    input logic             frozen
);
    // R1
    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (result == '0) && zero);

    // R8
    a_r8_freeze_keeps_value: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_we || b_we) && !f_we) |=> (result == $past(result)));

    // R8
    a_r8_freeze_enters_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_we || b_we) && !f_we) |=> frozen);

    // R9
    a_r9_moves_only_on_fn_write: assert property (@(posedge clk) disable iff (!rst_n)
        !f_we |=> $stable(result));

    // R10
    a_r10_fn_write_thaws: assert property (@(posedge clk) disable iff (!rst_n)
        f_we |=> !frozen);

    // R11
    a_r11_zero_matches_result: assert property (@(posedge clk) disable iff (!rst_n)
        zero == (result == '0));

endmodule

bind alu_offset_hold alu_offset_hold_checker #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_we   (a_we),
    .b_we   (b_we),
    .f_we   (f_we),
    .result (result),
    .zero   (zero),
    .frozen (frozen)
);

// File: tb/alu_offset_hold_test.sv
module alu_offset_hold_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_we = 1'b0, b_we = 1'b0, f_we = 1'b0;
    logic [7:0] a_wdata = '0, b_wdata = '0, f_wdata = '0;
    logic [7:0] result;
    logic       zero;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state
    int m_a = 0, m_b = 0, m_op = 0, m_snap = 0;
    bit m_held = 0;

    always #10 clk = ~clk;

    alu_offset_hold uut (
        .clk(clk), .rst_n(rst_n),
        .a_we(a_we), .a_wdata(a_wdata),
        .b_we(b_we), .b_wdata(b_wdata),
        .f_we(f_we), .f_wdata(f_wdata),
        .result(result), .zero(zero)
    );

    function automatic int ref_alu(int a, int b, int op);
        int fn;
        int ofs;
        int r;
        fn  = op % 16;
        ofs = (op / 32) % 8;
        if (ofs >= 4) ofs = ofs - 8;
        case (fn)
            0:  r = a;
            1:  r = b;
            2:  r = 255 - a;
            3:  r = 255 - b;
            4:  r = (a * 2) % 256;
            5:  r = (b * 2) % 256;
            6:  r = a / 2;
            7:  r = b / 2;
            8:  r = a & b;
            9:  r = a | b;
            10: r = a ^ b;
            11: r = (a + b) % 256;
            12: r = (a + b > 255) ? 1 : 0;
            13: r = (a < b) ? 255 : 0;
            14: r = (a == b) ? 255 : 0;
            default: r = (a > b) ? 255 : 0;
        endcase
        return (r + ofs + 256) % 256;
    endfunction

    function automatic int model_out();
        return m_held ? m_snap : ref_alu(m_a, m_b, m_op);
    endfunction

    task automatic compare(string tag);
        int  exp_r;
        bit  exp_z;
        exp_r = model_out();
        exp_z = (exp_r == 0);
        n_cmp++;
        if (result !== exp_r[7:0] || zero !== exp_z) begin
            n_bad++;
            $display("FAIL %s: result=%02h zero=%0b expected result=%02h zero=%0b",
                     tag, result, zero, exp_r[7:0], exp_z);
        end
    endtask

    task automatic model_step(bit aw, int ad, bit bw, int bd, bit fw, int fd);
        if (fw) begin
            m_op   = fd;
            m_held = 0;
        end else if ((aw || bw) && !m_held) begin
            m_snap = ref_alu(m_a, m_b, m_op);
            m_held = 1;
        end
        if (aw) m_a = ad;
        if (bw) m_b = bd;
    endtask

    task automatic cyc(bit aw, int ad, bit bw, int bd, bit fw, int fd, string tag);
        a_we = aw; a_wdata = ad[7:0];
        b_we = bw; b_wdata = bd[7:0];
        f_we = fw; f_wdata = fd[7:0];
        @(posedge clk);
        model_step(aw, ad, bw, bd, fw, fd);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_op(int a, int b, int f, string tag);
        cyc(1, a, 1, b, 0, 0, tag);
        cyc(0, 0, 0, 0, 1, f, tag);
        cyc(0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        // R1: outputs during and right after reset
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, 0, "R1");

        // R2: unary functions with zero fill
        for (int fn = 0; fn < 8; fn++) do_op(8'h81, 8'h3C, fn, "R2");
        for (int fn = 0; fn < 8; fn++) do_op(8'hFF, 8'h01, fn, "R2");
        // R3: bitwise pairs
        for (int fn = 8; fn < 11; fn++) do_op(8'hC5, 8'h5A, fn, "R3");
        // R4: sum and carry
        do_op(8'hF0, 8'h20, 11, "R4");
        do_op(8'hF0, 8'h20, 12, "R4");
        do_op(8'h10, 8'h20, 12, "R4");
        do_op(8'hFF, 8'h01, 12, "R4");
        // R5: unsigned comparisons
        for (int fn = 13; fn < 16; fn++) begin
            do_op(8'h01, 8'hFF, fn, "R5");
            do_op(8'hFF, 8'h01, fn, "R5");
            do_op(8'h77, 8'h77, fn, "R5");
        end
        // R6: signed offsets wrap
        do_op(8'h02, 8'h00, 8'h80, "R6");
        do_op(8'hFE, 8'h00, 8'h60, "R6");
        do_op(8'h00, 8'h00, 8'hE0, "R6");
        do_op(8'h10, 8'h20, 8'hAB, "R6");
        // R7: bit 4 ignored
        do_op(8'h81, 8'h00, 8'h14, "R7");
        do_op(8'h81, 8'h00, 8'h3E, "R7");
        // R11: offset bringing result to zero
        do_op(8'h04, 8'h00, 8'h80, "R11");
        do_op(8'h01, 8'h00, 8'hE0, "R11");
        // R8: freeze on operand write
        do_op(8'h21, 8'h13, 8'd11, "R8");
        cyc(1, 8'h99, 0, 0, 0, 0, "R8");
        // R9: further writes while frozen
        cyc(0, 0, 1, 8'h44, 0, 0, "R9");
        cyc(1, 8'h00, 1, 8'h00, 0, 0, "R9");
        cyc(0, 0, 0, 0, 0, 0, "R9");
        // R11: frozen zero flag keeps pace
        cyc(0, 0, 0, 0, 1, 8'd14, "R11");
        cyc(1, 8'h05, 0, 0, 0, 0, "R11");
        // R10: thaw, and same-cycle operand plus function write
        cyc(0, 0, 0, 0, 1, 8'd11, "R10");
        cyc(1, 8'h40, 0, 0, 1, 8'd0, "R10");
        cyc(0, 0, 1, 8'h09, 1, 8'd9, "R10");
        // R10: random strobe mix
        for (int i = 0; i < 600; i++) begin
            cyc($urandom_range(0, 1), $urandom_range(0, 255),
                $urandom_range(0, 1), $urandom_range(0, 255),
                ($urandom_range(0, 3) == 0), $urandom_range(0, 255), "R10");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule